// File: doc/BRIEF.md
# Longest Prefix Match Lookup

This block is a small forwarding-table engine for a packet path. Each lookup request carries a 32-bit destination address. The block answers with the output port of the table entry whose prefix matches that address with the greatest length. Every entry is compared at the same time, so a result always appears a fixed two cycles after the request is accepted, however the table is filled. When no entry matches, the result is flagged as a miss, and the packet can then be handed to the control processor.

Table entries are written one at a time through an update port. Each write gives an index, a network address, a prefix length, a port and a valid bit. Updates go straight into the table registers and never hold off requests. This way, a slow control path can rewrite routes while the lookup stream runs at one request per cycle.

Top module: `lpm_lookup`

## Requirements
- R1: An update with `upd_we` high writes address, prefix length, port and valid bit into entry `upd_idx`. A lookup accepted in the next cycle sees the new contents. A lookup accepted in the same cycle as the update sees the old contents.
- R2: A valid entry matches an address when the address and the entry's stored network address agree in their top L bits, where L is the prefix length. Bits of the written address below the prefix are dropped when the entry is stored.
- R3: When several entries match, the result port is that of the matching entry with the largest prefix length.
- R4: When matching entries share the largest prefix length, the one at the lowest index wins.
- R5: A prefix length of 0 matches every address and acts as a default route. Prefix lengths above 32 are treated as 32.
- R6: When nothing matches, the result has `res_hit` low and `res_port` zero.
- R7: An entry written with its valid bit low never matches.
- R8: `res_valid` pulses exactly two cycles after each accepted request, and back-to-back requests give back-to-back results.
- R9: `req_ready` is high in every cycle after reset, including cycles with updates.
- R10: After reset every entry is invalid, `res_valid` is low, and every lookup misses until an entry is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_we | input | 1 | Write strobe for a table entry |
| upd_idx | input | $clog2(ENTRIES) | Entry index to write |
| upd_addr | input | 32 | Network address of the entry |
| upd_plen | input | 6 | Prefix length, 0 to 32 |
| upd_port | input | PORT_W | Output port of the entry |
| upd_valid | input | 1 | Valid bit of the entry |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block accepts a request |
| req_addr | input | 32 | Destination address to look up |
| res_valid | output | 1 | Result pulse |
| res_hit | output | 1 | Some entry matched |
| res_port | output | PORT_W | Port of the winning entry, zero on a miss |

## Verification
The assertions check the following on every cycle:
- the stored network address has no bits below its prefix;
- a registered match never comes from an entry that was invalid;
- the chosen candidate is never beaten by a longer matching prefix, or by an equal-length match at a lower index;
- the result pulse follows each accepted request by two cycles;
- a miss shows port zero;
- ready stays high once reset is over.

Only the bench scenarios can show which port a given address resolves to. Examples are the overlapping /8, /16 and /18 routes, the default route, invalidation, and the timing of an update relative to a lookup in the same or the next cycle. The bench shows these by comparing against a reference table kept in the bench.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int ADDR_W = 32;
  localparam int PLEN_W = 6;

  // clamp a prefix length to the address width
  function automatic logic [PLEN_W-1:0] plen_clamp(input logic [PLEN_W-1:0] plen);
    return (plen > PLEN_W'(ADDR_W)) ? PLEN_W'(ADDR_W) : plen;
  endfunction

  // expand a prefix length into a left-aligned bitmask
  function automatic logic [ADDR_W-1:0] plen_mask(input logic [PLEN_W-1:0] plen);
    logic [PLEN_W-1:0] l;
    l = plen_clamp(plen);
    if (l == '0) return '0;
    return {ADDR_W{1'b1}} << (ADDR_W - int'(l));
  endfunction
endpackage

// File: rtl/lpm_table.sv
module lpm_table
  import lpm_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PORT_W  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              we,
  input  logic [IDX_W-1:0]                  idx,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [PLEN_W-1:0]                 plen,
  input  logic [PORT_W-1:0]                 port,
  input  logic                              valid,
  output logic [ENTRIES-1:0]                vld_o,
  output logic [ENTRIES-1:0][ADDR_W-1:0]    net_o,
  output logic [ENTRIES-1:0][PLEN_W-1:0]    len_o,
  output logic [ENTRIES-1:0][PORT_W-1:0]    port_o
);
  logic [ENTRIES-1:0]             vld_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] net_q;
  logic [ENTRIES-1:0][PLEN_W-1:0] len_q;
  logic [ENTRIES-1:0][PORT_W-1:0] port_q;

  // the valid bits need a reset, the payload does not
  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (we) vld_q[idx] <= valid;
  end

  // stored normalised: clamped length, host bits cleared
  always_ff @(posedge clk) begin
    if (we) begin
      net_q[idx]  <= addr & plen_mask(plen);
      len_q[idx]  <= plen_clamp(plen);
      port_q[idx] <= port;
    end
  end

  assign vld_o  = vld_q;
  assign net_o  = net_q;
  assign len_o  = len_q;
  assign port_o = port_q;

  p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
    we |=> vld_q[$past(idx)] == $past(valid));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
    p_net_masked_r2: assert property (@(posedge clk) disable iff (rst)
      vld_q[i] |-> ((net_q[i] & ~plen_mask(len_q[i])) == '0));
  end
endmodule

// File: rtl/lpm_compare.sv
module lpm_compare
  import lpm_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PORT_W  = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic [ADDR_W-1:0]                 in_addr,
  input  logic [ENTRIES-1:0]                vld,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]    net,
  input  logic [ENTRIES-1:0][PLEN_W-1:0]    len,
  input  logic [ENTRIES-1:0][PORT_W-1:0]    port,
  output logic                              s1_valid,
  output logic [ENTRIES-1:0]                hit_q,
  output logic [ENTRIES-1:0][PLEN_W-1:0]    len_q,
  output logic [ENTRIES-1:0][PORT_W-1:0]    port_q
);
  logic [ENTRIES-1:0] hit_d;

  // one comparator per entry, all in parallel
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_d[i] = vld[i] && ((in_addr & plen_mask(len[i])) == net[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      hit_q    <= '0;
    end else begin
      s1_valid <= in_valid;
      hit_q    <= in_valid ? hit_d : '0;
    end
  end

  // snapshot of length and port so a later update cannot skew stage two
  always_ff @(posedge clk) begin
    len_q  <= len;
    port_q <= port;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
    p_invalid_never_r7: assert property (@(posedge clk) disable iff (rst)
      hit_q[i] |-> $past(vld[i]));
  end
endmodule

// File: rtl/lpm_select.sv
module lpm_select
  import lpm_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PORT_W  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [ENTRIES-1:0]                hit,
  input  logic [ENTRIES-1:0][PLEN_W-1:0]    len,
  input  logic [ENTRIES-1:0][PORT_W-1:0]    port,
  output logic                              found,
  output logic [PORT_W-1:0]                 best_port
);
  logic [PLEN_W-1:0] best_len;
  logic [IDX_W-1:0]  best_idx;

  // strict greater-than keeps the lowest index among equal lengths
  always_comb begin
    found     = 1'b0;
    best_len  = '0;
    best_port = '0;
    best_idx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit[i] && (!found || len[i] > best_len)) begin
        found     = 1'b1;
        best_len  = len[i];
        best_port = port[i];
        best_idx  = IDX_W'(i);
      end
    end
  end

  // independent audits of the chosen candidate
  logic beaten_longer, beaten_tie;
  always_comb begin
    beaten_longer = 1'b0;
    beaten_tie    = 1'b0;
    for (int j = 0; j < ENTRIES; j++) begin
      if (hit[j] && len[j] > best_len) beaten_longer = 1'b1;
      if (hit[j] && len[j] == best_len && IDX_W'(j) < best_idx) beaten_tie = 1'b1;
    end
  end

  p_longest_wins_r3: assert property (@(posedge clk) disable iff (rst)
    found |-> !beaten_longer);
  p_tie_low_index_r4: assert property (@(posedge clk) disable iff (rst)
    found |-> !beaten_tie);
endmodule

// File: rtl/lpm_lookup.sv
module lpm_lookup
  import lpm_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PORT_W  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd_we,
  input  logic [IDX_W-1:0]     upd_idx,
  input  logic [ADDR_W-1:0]    upd_addr,
  input  logic [PLEN_W-1:0]    upd_plen,
  input  logic [PORT_W-1:0]    upd_port,
  input  logic                 upd_valid,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 res_valid,
  output logic                 res_hit,
  output logic [PORT_W-1:0]    res_port
);
  logic [ENTRIES-1:0]             t_vld;
  logic [ENTRIES-1:0][ADDR_W-1:0] t_net;
  logic [ENTRIES-1:0][PLEN_W-1:0] t_len;
  logic [ENTRIES-1:0][PORT_W-1:0] t_port;

  logic                           s1_valid;
  logic [ENTRIES-1:0]             s1_hit;
  logic [ENTRIES-1:0][PLEN_W-1:0] s1_len;
  logic [ENTRIES-1:0][PORT_W-1:0] s1_port;

  logic              sel_found;
  logic [PORT_W-1:0] sel_port;
  logic              ready_q;

  lpm_table #(.ENTRIES(ENTRIES), .PORT_W(PORT_W)) u_table (
    .clk(clk), .rst(rst), .we(upd_we), .idx(upd_idx), .addr(upd_addr),
    .plen(upd_plen), .port(upd_port), .valid(upd_valid),
    .vld_o(t_vld), .net_o(t_net), .len_o(t_len), .port_o(t_port)
  );

  lpm_compare #(.ENTRIES(ENTRIES), .PORT_W(PORT_W)) u_cmp (
    .clk(clk), .rst(rst), .in_valid(req_valid && ready_q), .in_addr(req_addr),
    .vld(t_vld), .net(t_net), .len(t_len), .port(t_port),
    .s1_valid(s1_valid), .hit_q(s1_hit), .len_q(s1_len), .port_q(s1_port)
  );

  lpm_select #(.ENTRIES(ENTRIES), .PORT_W(PORT_W)) u_sel (
    .clk(clk), .rst(rst), .hit(s1_hit), .len(s1_len), .port(s1_port),
    .found(sel_found), .best_port(sel_port)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q   <= 1'b0;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_port  <= '0;
    end else begin
      ready_q   <= 1'b1;
      res_valid <= s1_valid;
      res_hit   <= s1_valid && sel_found;
      res_port  <= (s1_valid && sel_found) ? sel_port : '0;
    end
  end

  assign req_ready = ready_q;

  p_fixed_latency_r8: assert property (@(posedge clk) disable iff (rst)
    res_valid == $past(req_valid && req_ready, 2));
  p_ready_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> req_ready);
  p_miss_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> res_port == '0);
  p_reset_empty_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !res_valid);
endmodule

// File: tb/tb_lpm_lookup.sv
module tb_lpm_lookup;
  localparam int N  = 8;
  localparam int PW = 4;
  localparam int IW = $clog2(N);

  logic clk = 0;
  logic rst = 1;
  logic upd_we = 0, upd_valid = 0, req_valid = 0;
  logic [IW-1:0] upd_idx = '0;
  logic [31:0] upd_addr = '0, req_addr = '0;
  logic [5:0]  upd_plen = '0;
  logic [PW-1:0] upd_port = '0;
  logic req_ready, res_valid, res_hit;
  logic [PW-1:0] res_port;

  always #2.5 clk = ~clk;

  lpm_lookup #(.ENTRIES(N), .PORT_W(PW)) dut (
    .clk(clk), .rst(rst), .upd_we(upd_we), .upd_idx(upd_idx), .upd_addr(upd_addr),
    .upd_plen(upd_plen), .upd_port(upd_port), .upd_valid(upd_valid),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_port(res_port)
  );

  int checks = 0, fails = 0;

  // reference table
  logic          m_vld [N];
  logic [31:0]   m_net [N];
  int            m_len [N];
  logic [PW-1:0] m_port[N];

  // two-deep pipe of expected results
  logic d1_v = 0, d2_v = 0, d1_h = 0, d2_h = 0;
  logic [PW-1:0] d1_p = '0, d2_p = '0;
  string d1_t = "", d2_t = "";

  function automatic logic [31:0] ref_mask(input int l);
    logic [31:0] m = '0;
    for (int b = 0; b < l && b < 32; b++) m[31-b] = 1'b1;
    return m;
  endfunction

  task automatic ref_lookup(input logic [31:0] a, output logic h, output logic [PW-1:0] p);
    int best = -1;
    h = 0; p = '0;
    for (int i = 0; i < N; i++)
      if (m_vld[i] && ((a & ref_mask(m_len[i])) == m_net[i]) && (best < 0 || m_len[i] > best)) begin
        best = m_len[i]; h = 1; p = m_port[i];
      end
  endtask

  task automatic check(input string tag, input logic ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // one cycle: check the output due now, then drive a request and an update
  task automatic step(input logic rv, input logic [31:0] ra, input string tag,
                      input logic uw, input int ui, input logic [31:0] ua,
                      input int ul, input logic [PW-1:0] up, input logic uv);
    logic h; logic [PW-1:0] p;
    @(negedge clk);
    if (d2_v)
      check(d2_t, res_valid && res_hit == d2_h && res_port == d2_p,
            $sformatf("valid/hit/port actual %0b/%0b/%0d expected 1/%0b/%0d",
                      res_valid, res_hit, res_port, d2_h, d2_p));
    else
      check("R8", !res_valid, $sformatf("res_valid actual %0b expected 0", res_valid));
    check("R9", req_ready, $sformatf("req_ready actual %0b expected 1", req_ready));
    d2_v = d1_v; d2_h = d1_h; d2_p = d1_p; d2_t = d1_t;
    ref_lookup(ra, h, p);
    d1_v = rv; d1_h = h; d1_p = p; d1_t = tag;
    req_valid = rv; req_addr = ra;
    upd_we = uw; upd_idx = IW'(ui); upd_addr = ua; upd_plen = 6'(ul);
    upd_port = up; upd_valid = uv;
    if (uw) begin
      int cl = (ul > 32) ? 32 : ul;
      m_vld[ui] = uv; m_len[ui] = cl; m_net[ui] = ua & ref_mask(cl); m_port[ui] = up;
    end
  endtask

  task automatic look(input logic [31:0] a, input string tag);
    step(1, a, tag, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input int i, input logic [31:0] a, input int l, input logic [PW-1:0] p, input logic v);
    step(0, 0, "", 1, i, a, l, p, v);
  endtask

  task automatic drain();
    repeat (3) step(0, 0, "", 0, 0, 0, 0, 0, 0);
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_net[i] = 0; m_len[i] = 0; m_port[i] = 0; end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R10", !res_valid, $sformatf("res_valid in reset actual %0b expected 0", res_valid));
    rst = 0;
    // R10: empty table misses
    look(32'h80201234, "R10"); look(32'h00000000, "R10");
    drain();
    // R2/R3 overlapping routes
    wr(0, 32'h80200105, 16, 1, 1);
    wr(1, 32'h8020E100, 18, 3, 1);
    wr(2, 32'h80000000, 8, 5, 1);
    look(32'h8020C301, "R3");
    look(32'h80200163, "R2");
    look(32'h80630000, "R2");
    look(32'h0A000001, "R6");
    // R4 tie, equal /16 at higher index
    wr(5, 32'h8020FFFF, 16, 9, 1);
    look(32'h80200101, "R4");
    // R5 default route and over-long length
    wr(7, 32'h12345678, 0, 12, 1);
    wr(6, 32'h0A010203, 40, 7, 1);
    look(32'h0A000001, "R5"); look(32'h0A010203, "R5"); look(32'h0A010204, "R5");
    // R7 invalidation
    wr(1, 32'h8020E100, 18, 3, 0);
    look(32'h8020C301, "R7");
    // R1 same-cycle update sees old, next cycle sees new
    step(1, 32'h8020C301, "R1", 1, 1, 32'h8020E100, 18, 3, 1);
    look(32'h8020C301, "R1");
    drain();
    // random mix with back-to-back lookups (R8)
    for (int k = 0; k < 800; k++) begin
      logic [31:0] a;
      int sel = int'($urandom_range(0, 3));
      a = $urandom;
      if (sel == 0) a[31:24] = 8'h80; else if (sel == 1) a[31:16] = 16'h8020; else if (sel == 2) a[31:24] = 8'h0A;
      if ($urandom_range(0, 3) == 0)
        step(int'($urandom_range(0, 1)) == 1, a, "R3", 1, int'($urandom_range(0, N-1)), $urandom,
             int'($urandom_range(0, 34)), PW'($urandom), $urandom_range(0, 4) != 0);
      else
        look(a, "R8");
    end
    drain();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule